// File: doc/BRIEF.md
# TLB Invalidation Sequencer

This block walks the entries of a two-part translation buffer and clears the exist bit of those an invalidation command selects. The buffer has a set-associative part (several ways of many sets, all at one fixed page size) and a small fully associative part, where each entry carries its own page size. The entry storage is outside the block. The sequencer puts out one entry address per clock and reads that entry's fields back in the same cycle. It asserts a clear strobe whenever the entry meets the rule of the active opcode.

A command is one cycle of `cmd_valid_i` with an opcode, an ASID, a global-bit value, a virtual address and an index. The block then stays busy for exactly the number of entries in the selected range and pulses `done_o` for one cycle. Commands that arrive while it is busy, or in the done cycle, are dropped. Entry addresses are linear. The set-associative part comes first: way `w` of set `s` sits at `w*SA_SETS + s`. The fully associative part follows from `SA_WAYS*SA_SETS` upward.

Top module: `tlbinv_engine`

## Requirements
- R1: After reset `busy_o`, `done_o` and `clr_o` are 0, and `clr_o` is only ever 1 while `busy_o` is 1.
- R2: Opcode 0 (clear all) visits every entry in ascending address order, one per cycle, for 2112 busy cycles with default parameters, and strobes every entry.
- R3: Opcode 1 sweeps all entries and clears those whose global bit equals `cmd_g_i`.
- R4: Opcode 2 sweeps all entries and clears those that are non-global with an ASID equal to `cmd_asid_i` (10 bits).
- R5: Opcode 3 sweeps all entries and clears existing non-global entries that have a matching ASID and whose page compares equal to `cmd_va_i`.
- R6: Opcode 4 sweeps all entries and clears existing entries that are global or ASID-matching and whose page compares equal to `cmd_va_i`.
- R7: The page compare matches address bits from position ps+1 upward against the entry's stored page number shifted left by 13. It takes ps from `pgsz_i` for set-associative entries and from `ent_ps_i` for fully associative entries. Opcodes 3 and 4 never strobe an entry whose exist bit is 0.
- R8: Opcode 5 (index flush) clears unconditionally. An index below 2048 visits the 8 ways of set (index mod 256), in way order, taking 8 cycles. An index from 2048 to 2111 visits the 64 fully associative entries. Any larger index visits nothing and gives 0 busy cycles.
- R9: Opcode 6 (index clear) covers the same ranges as opcode 5 but clears only non-global entries with a matching ASID.
- R10: `done_o` is a single-cycle pulse in the cycle after the last visited entry and is never high together with `busy_o`. A `cmd_valid_i` while busy or done has no effect on the range, the clears or the busy length.
- R11: Opcode 7 visits nothing: 0 busy cycles, then a done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command strobe, taken only when idle |
| cmd_op_i | input | 3 | Invalidation opcode (0..7) |
| cmd_asid_i | input | 10 | ASID to compare |
| cmd_g_i | input | 1 | Global-bit value for opcode 1 |
| cmd_va_i | input | 48 | Virtual address for page compares |
| cmd_idx_i | input | 12 | Entry index for opcodes 5 and 6 |
| pgsz_i | input | 6 | Fixed page-size exponent of the set-associative part |
| busy_o | output | 1 | High while entries are being visited |
| done_o | output | 1 | One-cycle completion pulse |
| ent_addr_o | output | 12 | Address of the entry visited this cycle |
| ent_exist_i | input | 1 | Exist bit of the addressed entry |
| ent_global_i | input | 1 | Global bit of the addressed entry |
| ent_asid_i | input | 10 | ASID of the addressed entry |
| ent_vppn_i | input | 35 | Stored page-pair number (address bits 47:13) |
| ent_ps_i | input | 6 | Page-size exponent of the addressed entry |
| clr_o | output | 1 | Clear the exist bit of `ent_addr_o` at this edge |

## Verification
A wrong range decode or a stuck step counter appears at once in the length of the busy window and in the sequence of `ent_addr_o`. Both show up in the first cycles of a command or when done arrives. A wrong predicate, or a captured command field that is overwritten, leaves the wrong exist bits set or cleared in the external storage. That is visible right after `done_o`, as a difference between the expected and the observed strobe count and per-entry state. Dropped or accepted stray commands show up as a busy window of the wrong length, or as a second window after the done pulse.

// File: rtl/tlbinv_pkg.sv
package tlbinv_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  typedef enum logic [2:0] {
    OP_ALL       = 3'd0,
    OP_BY_G      = 3'd1,
    OP_ASID      = 3'd2,
    OP_PG_ASID   = 3'd3,
    OP_PG_AG     = 3'd4,
    OP_IDX_FLUSH = 3'd5,
    OP_IDX_CLR   = 3'd6,
    OP_NOP       = 3'd7
  } inv_op_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_RUN  = 2'd1,
    S_DONE = 2'd2
  } walk_state_e;

  function automatic logic is_page_op(inv_op_e op);
    return (op == OP_PG_ASID) || (op == OP_PG_AG);
  endfunction
endpackage

// File: rtl/tlbinv_range.sv
module tlbinv_range
  import tlbinv_pkg::*;
#(
  parameter int SA_WAYS = 8,
  parameter int SA_SETS = 256,
  parameter int FA_N    = 64,
  localparam int SA_N   = SA_WAYS * SA_SETS,
  localparam int TOTAL  = SA_N + FA_N,
  localparam int IDX_W  = $clog2(TOTAL),
  localparam int CNT_W  = $clog2(TOTAL + 1),
  localparam int SET_W  = $clog2(SA_SETS)
) (
  input  inv_op_e          op_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [IDX_W-1:0] base_o,
  output logic [IDX_W-1:0] stride_o,
  output logic [CNT_W-1:0] len_o
);
  timeunit 1ns;
  timeprecision 1ps;

  always_comb begin
    base_o   = '0;
    stride_o = IDX_W'(1);
    len_o    = '0;
    case (op_i)
      OP_ALL, OP_BY_G, OP_ASID, OP_PG_ASID, OP_PG_AG: begin
        len_o = CNT_W'(TOTAL);
      end
      OP_IDX_FLUSH, OP_IDX_CLR: begin
        if (idx_i < IDX_W'(SA_N)) begin
          // one set, all ways: stride is the set count
          base_o   = IDX_W'(idx_i[SET_W-1:0]);
          stride_o = IDX_W'(SA_SETS);
          len_o    = CNT_W'(SA_WAYS);
        end else if (idx_i < IDX_W'(TOTAL)) begin
          base_o = IDX_W'(SA_N);
          len_o  = CNT_W'(FA_N);
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/tlbinv_match.sv
module tlbinv_match
  import tlbinv_pkg::*;
#(
  parameter int VA_W    = 48,
  parameter int VPN_LSB = 13,
  parameter int ASID_W  = 10,
  parameter int PS_W    = 6,
  parameter int IDX_W   = 12,
  parameter int SA_N    = 2048,
  localparam int VPN_W  = VA_W - VPN_LSB
) (
  input  inv_op_e           op_i,
  input  logic [ASID_W-1:0] asid_i,
  input  logic              g_i,
  input  logic [VA_W-1:0]   va_i,
  input  logic [PS_W-1:0]   sa_ps_i,
  input  logic [IDX_W-1:0]  addr_i,
  input  logic              ent_exist_i,
  input  logic              ent_global_i,
  input  logic [ASID_W-1:0] ent_asid_i,
  input  logic [VPN_W-1:0]  ent_vppn_i,
  input  logic [PS_W-1:0]   ent_ps_i,
  output logic              hit_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [PS_W-1:0] ps_sel;
  logic [VA_W-1:0] ent_va;
  logic [VA_W-1:0] keep;
  logic            page_hit;
  logic            asid_eq;

  assign ps_sel = (addr_i < IDX_W'(SA_N)) ? sa_ps_i : ent_ps_i;
  assign ent_va = {ent_vppn_i, {VPN_LSB{1'b0}}};

  // keep address bits above the page-pair boundary (bit ps+1 and up)
  for (genvar b = 0; b < VA_W; b++) begin : g_keep
    assign keep[b] = (PS_W + 1)'(b) > {1'b0, ps_sel};
  end

  assign page_hit = ((va_i ^ ent_va) & keep) == '0;
  assign asid_eq  = ent_asid_i == asid_i;

  always_comb begin
    case (op_i)
      OP_ALL:       hit_o = 1'b1;
      OP_BY_G:      hit_o = ent_global_i == g_i;
      OP_ASID:      hit_o = !ent_global_i && asid_eq;
      OP_PG_ASID:   hit_o = ent_exist_i && !ent_global_i && asid_eq && page_hit;
      OP_PG_AG:     hit_o = ent_exist_i && (ent_global_i || asid_eq) && page_hit;
      OP_IDX_FLUSH: hit_o = 1'b1;
      OP_IDX_CLR:   hit_o = !ent_global_i && asid_eq;
      default:      hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/tlbinv_walker.sv
module tlbinv_walker
  import tlbinv_pkg::*;
#(
  parameter int IDX_W = 12,
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [IDX_W-1:0] base_i,
  input  logic [IDX_W-1:0] stride_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             ready_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [IDX_W-1:0] addr_o
);
  timeunit 1ns;
  timeprecision 1ps;

  walk_state_e      state_q;
  logic [IDX_W-1:0] addr_q;
  logic [IDX_W-1:0] stride_q;
  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      addr_q   <= '0;
      stride_q <= IDX_W'(1);
      left_q   <= '0;
    end else begin
      case (state_q)
        S_IDLE: begin
          if (start_i) begin
            addr_q   <= base_i;
            stride_q <= stride_i;
            left_q   <= len_i;
            state_q  <= (len_i == '0) ? S_DONE : S_RUN;
          end
        end
        S_RUN: begin
          addr_q <= addr_q + stride_q;
          left_q <= left_q - CNT_W'(1);
          if (left_q == CNT_W'(1)) state_q <= S_DONE;
        end
        S_DONE:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign ready_o = state_q == S_IDLE;
  assign busy_o  = state_q == S_RUN;
  assign done_o  = state_q == S_DONE;
  assign addr_o  = addr_q;
endmodule

// File: rtl/tlbinv_engine.sv
module tlbinv_engine
  import tlbinv_pkg::*;
#(
  parameter int SA_WAYS = 8,
  parameter int SA_SETS = 256,
  parameter int FA_N    = 64,
  parameter int VA_W    = 48,
  parameter int VPN_LSB = 13,
  parameter int ASID_W  = 10,
  parameter int PS_W    = 6,
  localparam int SA_N   = SA_WAYS * SA_SETS,
  localparam int TOTAL  = SA_N + FA_N,
  localparam int IDX_W  = $clog2(TOTAL),
  localparam int CNT_W  = $clog2(TOTAL + 1),
  localparam int VPN_W  = VA_W - VPN_LSB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_op_i,
  input  logic [ASID_W-1:0] cmd_asid_i,
  input  logic              cmd_g_i,
  input  logic [VA_W-1:0]   cmd_va_i,
  input  logic [IDX_W-1:0]  cmd_idx_i,
  input  logic [PS_W-1:0]   pgsz_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [IDX_W-1:0]  ent_addr_o,
  input  logic              ent_exist_i,
  input  logic              ent_global_i,
  input  logic [ASID_W-1:0] ent_asid_i,
  input  logic [VPN_W-1:0]  ent_vppn_i,
  input  logic [PS_W-1:0]   ent_ps_i,
  output logic              clr_o
);
  timeunit 1ns;
  timeprecision 1ps;

  inv_op_e           op_q;
  logic [ASID_W-1:0] asid_q;
  logic              g_q;
  logic [VA_W-1:0]   va_q;
  logic [PS_W-1:0]   ps_q;

  logic              ready;
  logic              accept;
  logic              hit;
  logic [IDX_W-1:0]  base;
  logic [IDX_W-1:0]  stride;
  logic [CNT_W-1:0]  len;

  assign accept = cmd_valid_i && ready;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= OP_NOP;
      asid_q <= '0;
      g_q    <= 1'b0;
      va_q   <= '0;
      ps_q   <= '0;
    end else if (accept) begin
      op_q   <= inv_op_e'(cmd_op_i);
      asid_q <= cmd_asid_i;
      g_q    <= cmd_g_i;
      va_q   <= cmd_va_i;
      ps_q   <= pgsz_i;
    end
  end

  tlbinv_range #(
    .SA_WAYS(SA_WAYS), .SA_SETS(SA_SETS), .FA_N(FA_N)
  ) u_range (
    .op_i    (inv_op_e'(cmd_op_i)),
    .idx_i   (cmd_idx_i),
    .base_o  (base),
    .stride_o(stride),
    .len_o   (len)
  );

  tlbinv_walker #(
    .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_walker (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (accept),
    .base_i  (base),
    .stride_i(stride),
    .len_i   (len),
    .ready_o (ready),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .addr_o  (ent_addr_o)
  );

  tlbinv_match #(
    .VA_W(VA_W), .VPN_LSB(VPN_LSB), .ASID_W(ASID_W), .PS_W(PS_W),
    .IDX_W(IDX_W), .SA_N(SA_N)
  ) u_match (
    .op_i        (op_q),
    .asid_i      (asid_q),
    .g_i         (g_q),
    .va_i        (va_q),
    .sa_ps_i     (ps_q),
    .addr_i      (ent_addr_o),
    .ent_exist_i (ent_exist_i),
    .ent_global_i(ent_global_i),
    .ent_asid_i  (ent_asid_i),
    .ent_vppn_i  (ent_vppn_i),
    .ent_ps_i    (ent_ps_i),
    .hit_o       (hit)
  );

  assign clr_o = busy_o && hit;
endmodule

// File: rtl/tlbinv_engine_chk.sv
module tlbinv_engine_chk
  import tlbinv_pkg::*;
#(
  parameter int ASID_W = 10,
  parameter int IDX_W  = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy,
  input logic              done,
  input logic              clr,
  input logic [IDX_W-1:0]  addr,
  input logic              exist,
  input logic              glob,
  input logic [ASID_W-1:0] asid,
  input inv_op_e           op_q,
  input logic [ASID_W-1:0] asid_q
);
  timeunit 1ns;
  timeprecision 1ps;

  a_r1_clr_in_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |-> busy);

  a_r10_busy_done_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy && done));

  a_r10_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> !done);

  a_r10_done_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> done);

  a_r2_addr_ascend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy) && op_q == OP_ALL) |-> addr == $past(addr) + IDX_W'(1));

  a_r4_asid_guard: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr && op_q == OP_ASID) |-> (!glob && asid == asid_q));

  a_r7_skip_absent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr && is_page_op(op_q)) |-> exist);
endmodule

bind tlbinv_engine tlbinv_engine_chk #(.ASID_W(ASID_W), .IDX_W(IDX_W)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .busy  (busy_o),
  .done  (done_o),
  .clr   (clr_o),
  .addr  (ent_addr_o),
  .exist (ent_exist_i),
  .glob  (ent_global_i),
  .asid  (ent_asid_i),
  .op_q  (op_q),
  .asid_q(asid_q)
);

// File: tb/tlbinv_engine_bench.sv
module tlbinv_engine_bench;
  import tlbinv_pkg::*;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int SA_N  = 2048;
  localparam int SETS  = 256;
  localparam int TOTAL = 2112;

  typedef struct packed {
    inv_op_e     op;
    logic [9:0]  asid;
    logic        g;
    logic [47:0] va;
    logic [11:0] idx;
    logic [5:0]  psz;
    int          cyc;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{OP_ALL,       10'd0, 1'b0, 48'h0,            12'd0,    6'd13, 2112},
    '{OP_BY_G,      10'd0, 1'b1, 48'h0,            12'd0,    6'd13, 2112},
    '{OP_BY_G,      10'd0, 1'b0, 48'h0,            12'd0,    6'd13, 2112},
    '{OP_ASID,      10'd2, 1'b0, 48'h0,            12'd0,    6'd13, 2112},
    '{OP_PG_ASID,   10'd1, 1'b0, 48'h0000_0001_2000, 12'd0,  6'd13, 2112},
    '{OP_PG_AG,     10'd1, 1'b0, 48'h0000_0001_2000, 12'd0,  6'd13, 2112},
    '{OP_PG_ASID,   10'd0, 1'b0, 48'h0002_0010_1234, 12'd0,  6'd13, 2112},
    '{OP_PG_AG,     10'd1, 1'b0, 48'h0000_0005_0000, 12'd0,  6'd14, 2112},
    '{OP_IDX_FLUSH, 10'd0, 1'b0, 48'h0,            12'd261,  6'd13, 8},
    '{OP_IDX_CLR,   10'd3, 1'b0, 48'h0,            12'd777,  6'd13, 8},
    '{OP_IDX_FLUSH, 10'd0, 1'b0, 48'h0,            12'd2100, 6'd13, 64},
    '{OP_IDX_CLR,   10'd1, 1'b0, 48'h0,            12'd2060, 6'd13, 64},
    '{OP_IDX_FLUSH, 10'd0, 1'b0, 48'h0,            12'd3000, 6'd13, 0},
    '{OP_NOP,       10'd0, 1'b0, 48'h0,            12'd5,    6'd13, 0}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [2:0]  cmd_op;
  logic [9:0]  cmd_asid;
  logic        cmd_g;
  logic [47:0] cmd_va;
  logic [11:0] cmd_idx;
  logic [5:0]  pgsz;
  logic        busy, done, clr;
  logic [11:0] ent_addr;
  logic        ent_exist, ent_global;
  logic [9:0]  ent_asid;
  logic [34:0] ent_vppn;
  logic [5:0]  ent_ps;

  bit          m_exist [TOTAL];
  bit          m_g     [TOTAL];
  logic [9:0]  m_asid  [TOTAL];
  logic [34:0] m_vppn  [TOTAL];
  logic [5:0]  m_ps    [TOTAL];
  bit          snap    [TOTAL];

  int total = 0;
  int bad   = 0;
  int strobes = 0;
  int ticks = 0;

  always #2.5 clk = ~clk;

  tlbinv_engine u_tlbinv_engine (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_asid_i(cmd_asid), .cmd_g_i(cmd_g), .cmd_va_i(cmd_va), .cmd_idx_i(cmd_idx),
    .pgsz_i(pgsz), .busy_o(busy), .done_o(done), .ent_addr_o(ent_addr),
    .ent_exist_i(ent_exist), .ent_global_i(ent_global), .ent_asid_i(ent_asid),
    .ent_vppn_i(ent_vppn), .ent_ps_i(ent_ps), .clr_o(clr)
  );

  wire in_rng = int'(ent_addr) < TOTAL;
  assign ent_exist  = in_rng ? m_exist[int'(ent_addr)] : 1'b0;
  assign ent_global = in_rng ? m_g[int'(ent_addr)]     : 1'b0;
  assign ent_asid   = in_rng ? m_asid[int'(ent_addr)]  : '0;
  assign ent_vppn   = in_rng ? m_vppn[int'(ent_addr)]  : '0;
  assign ent_ps     = in_rng ? m_ps[int'(ent_addr)]    : '0;

  always @(posedge clk) begin
    if (clr) begin
      strobes = strobes + 1;
      if (int'(ent_addr) < TOTAL) m_exist[int'(ent_addr)] = 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic fill(input int seed);
    for (int i = 0; i < TOTAL; i++) begin
      m_exist[i] = ((i * 7 + seed) % 11) != 0;
      m_g[i]     = (i % 8) == 0;
      m_asid[i]  = 10'((i >> 3) % 4);
      if (i < SA_N) begin
        m_vppn[i] = 35'(i);
        m_ps[i]   = 6'd0;
      end else begin
        m_vppn[i] = 35'((i - SA_N) * 64 + 'h100000);
        m_ps[i]   = 6'(13 + (i % 3) * 4);
      end
    end
  endtask

  function automatic string op_tag(inv_op_e op);
    case (op)
      OP_ALL:       return "R2";
      OP_BY_G:      return "R3";
      OP_ASID:      return "R4";
      OP_PG_ASID:   return "R5";
      OP_PG_AG:     return "R6";
      OP_IDX_FLUSH: return "R8";
      OP_IDX_CLR:   return "R9";
      default:      return "R11";
    endcase
  endfunction

  // reference rule taken from the requirements
  function automatic bit ref_hit(int i, vec_t v);
    bit in_set, in_fa, pg, aeq;
    longint unsigned vaw, ev;
    int ps;
    in_set = (int'(v.idx) < SA_N) && (i < SA_N) && ((i % SETS) == (int'(v.idx) % SETS));
    in_fa  = (int'(v.idx) >= SA_N) && (int'(v.idx) < TOTAL) && (i >= SA_N);
    ps  = (i < SA_N) ? int'(v.psz) : int'(m_ps[i]);
    vaw = longint'(v.va);
    ev  = longint'(m_vppn[i]) << 13;
    pg  = (vaw >> (ps + 1)) == (ev >> (ps + 1));
    aeq = m_asid[i] == v.asid;
    case (v.op)
      OP_ALL:       return 1'b1;
      OP_BY_G:      return m_g[i] == v.g;
      OP_ASID:      return !m_g[i] && aeq;
      OP_PG_ASID:   return m_exist[i] && !m_g[i] && aeq && pg;
      OP_PG_AG:     return m_exist[i] && (m_g[i] || aeq) && pg;
      OP_IDX_FLUSH: return in_set || in_fa;
      OP_IDX_CLR:   return (in_set || in_fa) && !m_g[i] && aeq;
      default:      return 1'b0;
    endcase
  endfunction

  task automatic run_vec(input vec_t v, input bit inject);
    int cyc, guard, n_exp, n_mis;
    bit exp_clr [TOTAL];
    string tg;
    tg = op_tag(v.op);
    n_exp = 0;
    for (int i = 0; i < TOTAL; i++) begin
      exp_clr[i] = ref_hit(i, v);
      if (exp_clr[i]) n_exp++;
      snap[i] = m_exist[i];
    end
    @(negedge clk);
    strobes   = 0;
    cmd_valid = 1'b1;
    cmd_op    = v.op;
    cmd_asid  = v.asid;
    cmd_g     = v.g;
    cmd_va    = v.va;
    cmd_idx   = v.idx;
    pgsz      = v.psz;
    @(negedge clk);
    cmd_valid = 1'b0;
    cyc = 0;
    guard = 0;
    while (!done && guard < 5000) begin
      if (busy) cyc++;
      // stray command in the middle of the sweep (R10)
      if (inject && cyc == 3) begin
        cmd_valid = 1'b1;
        cmd_op    = OP_ALL;
      end else begin
        cmd_valid = 1'b0;
      end
      @(negedge clk);
      guard++;
    end
    check(done == 1'b1, tg, "done seen", longint'(done), 1);
    if (inject) begin
      cmd_valid = 1'b1;
      cmd_op    = OP_ALL;
    end
    @(negedge clk);
    cmd_valid = 1'b0;
    check(cyc == v.cyc, tg, "busy cycles", cyc, v.cyc);
    check(!done && !busy, "R10", "single done, no restart", {done, busy}, 0);
    check(strobes == n_exp, tg, "clear strobes", strobes, n_exp);
    n_mis = 0;
    for (int i = 0; i < TOTAL; i++)
      if (m_exist[i] != (snap[i] && !exp_clr[i])) n_mis++;
    check(n_mis == 0, tg, "entries differing", n_mis, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      ticks++;
      if (ticks > 150000) begin
        bad++;
        total++;
        $display("FAIL watchdog: actual=%0d expected<=150000", ticks);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    vec_t v;
    rst_n = 1'b0;
    cmd_valid = 1'b0; cmd_op = '0; cmd_asid = '0; cmd_g = 1'b0;
    cmd_va = '0; cmd_idx = '0; pgsz = 6'd13;
    fill(0);
    repeat (3) @(negedge clk);
    check(!busy && !done && !clr, "R1", "outputs in reset", {busy, done, clr}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && !done && !clr, "R1", "outputs after reset", {busy, done, clr}, 0);

    for (int k = 0; k < NV; k++) begin
      fill(k);
      run_vec(VECS[k], 1'b0);
    end

    // R10: stray commands during a set flush and in its done cycle
    fill(1);
    v = '{OP_IDX_FLUSH, 10'd0, 1'b0, 48'h0, 12'd5, 6'd13, 8};
    run_vec(v, 1'b1);

    // R7: absent entry 9 skipped, global entry 8 cleared, hand-derived
    fill(3);
    v = '{OP_PG_AG, 10'd1, 1'b0, 48'h0000_0001_2000, 12'd0, 6'd13, 2112};
    run_vec(v, 1'b0);
    check(strobes == 1, "R7", "strobes with absent entry", strobes, 1);
    check(m_exist[8] == 1'b0, "R7", "global entry 8 cleared", longint'(m_exist[8]), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule